// File: doc/BRIEF.md
# Keyed Diagnostic Access Gate

This block sits between a host register port and an internal bus. It holds a small register window, and through it the host can reach dwords on the internal bus. The path to the internal bus stays closed until the host writes one exact key value into the key register. Any other value written there closes the path again at once. While the gate is open, the host first loads an internal-bus address into an address register. It can then read or write the dword at that address through a data register.

Every host request carries a flag that names the address space it came from: I/O or memory. The data register works only for I/O-space requests. A memory-space read of it returns all ones, and a memory-space write to it is dropped. In neither case is there any bus traffic.

The host side uses two valid/ready channels. A request is accepted on a cycle where both `host_req_valid` and `host_req_ready` are high. One request is in flight at a time, so `host_req_ready` stays low from acceptance until its response has been taken. Every request gets exactly one response beat. That beat stays on `host_rsp_valid`/`host_rsp_rdata`, unchanged, until `host_rsp_ready` is high. The internal-bus request follows the same rules: it is held stable until `bus_req_ready`. The bus returns a single `bus_rsp_valid` pulse, and the block accepts it only while it waits for one.

Top module: `diag_unlock_gate`

## Requirements
- R1: After reset the gate is locked, the address register is 0, `host_req_ready` is 1, and both `host_rsp_valid` and `bus_req_valid` are 0.
- R2: A write to register index 0 with a value equal to the parameter `DIAG_KEY` opens the gate. A read of index 0 returns the gate state in bit 0 (1 = open), with the other bits zero. A request is accepted from either address space.
- R3: A write to index 0 with any value other than `DIAG_KEY` closes the gate. The closed state is visible on the next read of index 0.
- R4: A write to the address register (index 1) takes effect only while the gate is open; while it is closed the register keeps its value. A read of index 1 returns the register in either address space.
- R5: An I/O-space write to the data register (index 2) while the gate is open issues exactly one internal-bus write. That write carries the address register and the host data. The host response (data 0) comes only after the bus response.
- R6: An I/O-space read of index 2 while the gate is open issues exactly one internal-bus read at the address register. The host response is withheld until the bus answers and then carries the bus data.
- R7: A memory-space access to index 2 makes no bus request. A read returns 0xFFFFFFFF; a write is dropped and answers 0.
- R8: An access to index 2 while the gate is closed makes no bus request. A read returns 0xFFFFFFFF; a write is dropped and answers 0.
- R9: `host_req_ready` is low while a request is in flight. A pending host response holds its data until taken. A pending bus request holds address, data and direction until accepted.
- R10: Index 3 reads as 0, and writes to it change nothing. Write responses for indexes 0, 1 and 3 carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req_valid | input | 1 | Host request present |
| host_req_ready | output | 1 | Block can take a host request |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_io | input | 1 | 1 = I/O space, 0 = memory space |
| host_req_idx | input | 2 | Register index: 0 key/status, 1 address, 2 data, 3 reserved |
| host_req_wdata | input | DATA_W | Host write data |
| host_rsp_valid | output | 1 | Response beat present |
| host_rsp_ready | input | 1 | Host takes the response |
| host_rsp_rdata | output | DATA_W | Response data |
| bus_req_valid | output | 1 | Internal-bus request present |
| bus_req_ready | input | 1 | Internal bus takes the request |
| bus_req_write | output | 1 | Internal-bus direction, 1 = write |
| bus_req_addr | output | ADDR_W | Internal-bus dword address |
| bus_req_wdata | output | DATA_W | Internal-bus write data |
| bus_rsp_valid | input | 1 | Internal-bus completion pulse |
| bus_rsp_rdata | input | DATA_W | Internal-bus read data |

## Verification
The assertions rely on two things the environment must do. The host holds a request's fields steady while `host_req_valid` is high and not yet accepted. The internal bus raises `bus_rsp_valid` only once, and only after it has taken a request. The bench's bus responder acknowledges a request only after that request is accepted. It then returns a single response pulse after a random delay and never answers unprompted. The bench's host driver keeps each request constant until it sees `host_req_ready`, and it throttles `host_rsp_ready` at random to exercise response back-pressure.

// File: rtl/diag_gate_pkg.sv
package diag_gate_pkg;
  localparam int IDX_W = 2;

  typedef enum logic [IDX_W-1:0] {
    IDX_KEY  = 2'd0,
    IDX_ADDR = 2'd1,
    IDX_DATA = 2'd2,
    IDX_RSVD = 2'd3
  } reg_idx_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_BUS_REQ  = 2'd1,
    ST_BUS_WAIT = 2'd2,
    ST_RESP     = 2'd3
  } seq_state_e;
endpackage

// File: rtl/diag_key_lock.sv
module diag_key_lock #(
  parameter int          DATA_W = 32,
  parameter logic [31:0] KEY    = 32'hC0DE_5EED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr_en,
  input  logic [DATA_W-1:0] key_wr_data,
  output logic              unlocked
);
  localparam logic [DATA_W-1:0] KEY_W = DATA_W'(KEY);

  always_ff @(posedge clk) begin
    if (!rst_n)         unlocked <= 1'b0;
    else if (key_wr_en) unlocked <= (key_wr_data == KEY_W);
  end

  // R2: the exact key opens the gate on the next cycle
  assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr_en && key_wr_data == KEY_W) |=> unlocked);

  // R3: any other value closes it
  assert_bad_key_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr_en && key_wr_data != KEY_W) |=> !unlocked);
endmodule

// File: rtl/diag_addr_reg.sv
module diag_addr_reg #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              unlocked,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] addr_rb
);
  always_ff @(posedge clk) begin
    if (!rst_n)                addr <= '0;
    else if (wr_en && unlocked) addr <= wr_data[ADDR_W-1:0];
  end

  generate
    if (ADDR_W < DATA_W) begin : g_pad
      assign addr_rb = {{(DATA_W-ADDR_W){1'b0}}, addr};
    end else begin : g_full
      assign addr_rb = addr;
    end
  endgenerate

  // R4: a closed gate freezes the address register
  assert_addr_frozen_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(addr));
endmodule

// File: rtl/diag_access_seq.sv
module diag_access_seq
  import diag_gate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_write,
  input  logic              host_req_io,
  input  logic [IDX_W-1:0]  host_req_idx,
  input  logic [DATA_W-1:0] host_req_wdata,
  output logic              host_rsp_valid,
  input  logic              host_rsp_ready,
  output logic [DATA_W-1:0] host_rsp_rdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_write,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic [DATA_W-1:0] bus_rsp_rdata,
  input  logic              unlocked,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] addr_rb,
  output logic              key_wr_en,
  output logic              addr_wr_en
);
  seq_state_e        state_q;
  logic              q_write;
  logic [DATA_W-1:0] q_wdata;
  logic [DATA_W-1:0] rsp_q;
  logic              accept;
  logic              bus_go;
  logic [DATA_W-1:0] local_rdata;
  reg_idx_e          idx;

  assign idx            = reg_idx_e'(host_req_idx);
  assign host_req_ready = (state_q == ST_IDLE);
  assign accept         = host_req_valid && host_req_ready;
  assign bus_go         = (idx == IDX_DATA) && host_req_io && unlocked;
  assign key_wr_en      = accept && host_req_write && (idx == IDX_KEY);
  assign addr_wr_en     = accept && host_req_write && (idx == IDX_ADDR);

  always_comb begin
    local_rdata = '0;
    if (!host_req_write) begin
      unique case (idx)
        IDX_KEY:  local_rdata = {{(DATA_W-1){1'b0}}, unlocked};
        IDX_ADDR: local_rdata = addr_rb;
        IDX_DATA: local_rdata = '1;
        IDX_RSVD: local_rdata = '0;
        default:  local_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      q_write <= 1'b0;
      q_wdata <= '0;
      rsp_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (bus_go) begin
            state_q <= ST_BUS_REQ;
            q_write <= host_req_write;
            q_wdata <= host_req_wdata;
          end else begin
            state_q <= ST_RESP;
            rsp_q   <= local_rdata;
          end
        end
        ST_BUS_REQ:  if (bus_req_ready) state_q <= ST_BUS_WAIT;
        ST_BUS_WAIT: if (bus_rsp_valid) begin
          state_q <= ST_RESP;
          rsp_q   <= q_write ? '0 : bus_rsp_rdata;
        end
        ST_RESP:     if (host_rsp_ready) state_q <= ST_IDLE;
        default:     state_q <= ST_IDLE;
      endcase
    end
  end

  assign host_rsp_valid = (state_q == ST_RESP);
  assign host_rsp_rdata = rsp_q;
  assign bus_req_valid  = (state_q == ST_BUS_REQ);
  assign bus_req_write  = q_write;
  assign bus_req_addr   = addr;
  assign bus_req_wdata  = q_wdata;

  // R9: no new request while a response waits
  assert_busy_blocks_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid |-> !host_req_ready);

  // R9: response beat held until taken
  assert_rsp_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rsp_valid && !host_rsp_ready) |=> (host_rsp_valid && $stable(host_rsp_rdata)));

  // R9: bus request held until accepted
  assert_bus_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=>
      (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_wdata) && $stable(bus_req_write)));

  // R8: bus traffic only with the gate open
  assert_bus_needs_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> unlocked);
endmodule

// File: rtl/diag_unlock_gate.sv
module diag_unlock_gate
  import diag_gate_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] DIAG_KEY = 32'hC0DE_5EED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_write,
  input  logic              host_req_io,
  input  logic [1:0]        host_req_idx,
  input  logic [DATA_W-1:0] host_req_wdata,
  output logic              host_rsp_valid,
  input  logic              host_rsp_ready,
  output logic [DATA_W-1:0] host_rsp_rdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_write,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic [DATA_W-1:0] bus_rsp_rdata
);
  logic              unlocked;
  logic              key_wr_en;
  logic              addr_wr_en;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] addr_rb;

  diag_key_lock #(.DATA_W(DATA_W), .KEY(DIAG_KEY)) u_key (
    .clk(clk), .rst_n(rst_n), .key_wr_en(key_wr_en),
    .key_wr_data(host_req_wdata), .unlocked(unlocked)
  );

  diag_addr_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .wr_en(addr_wr_en), .unlocked(unlocked),
    .wr_data(host_req_wdata), .addr(addr), .addr_rb(addr_rb)
  );

  diag_access_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
    .host_req_write(host_req_write), .host_req_io(host_req_io),
    .host_req_idx(host_req_idx), .host_req_wdata(host_req_wdata),
    .host_rsp_valid(host_rsp_valid), .host_rsp_ready(host_rsp_ready),
    .host_rsp_rdata(host_rsp_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
    .bus_req_wdata(bus_req_wdata), .bus_rsp_valid(bus_rsp_valid),
    .bus_rsp_rdata(bus_rsp_rdata),
    .unlocked(unlocked), .addr(addr), .addr_rb(addr_rb),
    .key_wr_en(key_wr_en), .addr_wr_en(addr_wr_en)
  );

  // R7: a memory-space data access never reaches the bus
  assert_mem_space_no_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req_valid && host_req_ready && !host_req_io && host_req_idx == 2'd2) |=> !bus_req_valid);
endmodule

// File: tb/diag_unlock_gate_bench.sv
module diag_unlock_gate_bench;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] KEY        = 32'h9A3F_61C4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req_valid = 1'b0, host_req_write = 1'b0, host_req_io = 1'b0;
  logic [1:0]  host_req_idx = 2'd0;
  logic [31:0] host_req_wdata = '0;
  logic        host_req_ready, host_rsp_valid;
  logic        host_rsp_ready = 1'b0;
  logic [31:0] host_rsp_rdata;
  logic        bus_req_valid, bus_req_write;
  logic        bus_req_ready = 1'b0;
  logic [31:0] bus_req_addr, bus_req_wdata;
  logic        bus_rsp_valid = 1'b0;
  logic [31:0] bus_rsp_rdata = '0;

  int checks = 0, errors = 0;
  int bus_cnt = 0, bus_rsp_cnt = 0;
  logic [31:0] last_addr = '0, last_wdata = '0;
  logic        last_write = 1'b0;
  logic        m_open = 1'b0;
  logic [31:0] m_addr = '0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  diag_unlock_gate #(.ADDR_W(32), .DATA_W(32), .DIAG_KEY(KEY)) u_diag_unlock_gate (
    .clk(clk), .rst_n(rst_n),
    .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
    .host_req_write(host_req_write), .host_req_io(host_req_io),
    .host_req_idx(host_req_idx), .host_req_wdata(host_req_wdata),
    .host_rsp_valid(host_rsp_valid), .host_rsp_ready(host_rsp_ready),
    .host_rsp_rdata(host_rsp_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
    .bus_req_wdata(bus_req_wdata), .bus_rsp_valid(bus_rsp_valid),
    .bus_rsp_rdata(bus_rsp_rdata)
  );

  function automatic logic [31:0] bus_data(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1234_8765;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // internal-bus responder, driven on falling edges
  initial begin
    bit acc = 0, pend = 0;
    int wcnt = 0;
    logic [31:0] paddr = '0;
    forever begin
      @(negedge clk);
      bus_rsp_valid = 1'b0;
      if (acc) begin
        acc = 0; pend = 1; wcnt = $urandom % 4;
        bus_cnt++; bus_rsp_cnt = bus_rsp_cnt;
      end
      if (pend) begin
        if (wcnt == 0) begin
          bus_rsp_valid = 1'b1;
          bus_rsp_rdata = last_write ? 32'hDEAD_0000 : bus_data(paddr);
          bus_rsp_cnt++;
          pend = 0;
        end else wcnt--;
      end
      bus_req_ready = bus_req_valid && !pend && !acc && ($urandom % 2 == 0);
      if (bus_req_ready) begin
        acc = 1; paddr = bus_req_addr;
        last_addr = bus_req_addr; last_wdata = bus_req_wdata; last_write = bus_req_write;
      end
    end
  end

  task automatic access(input bit wr, input bit io, input logic [1:0] idx,
                        input logic [31:0] wd, output logic [31:0] rd);
    bit got = 0;
    host_req_valid = 1'b1; host_req_write = wr; host_req_io = io;
    host_req_idx = idx; host_req_wdata = wd;
    while (!host_req_ready) @(negedge clk);
    @(negedge clk);
    host_req_valid = 1'b0;
    check(!host_req_ready, "R9 ready low in flight", {31'b0, host_req_ready}, 32'd0);
    while (!got) begin
      host_rsp_ready = ($urandom % 4) != 0;
      if (host_rsp_valid && host_rsp_ready) begin rd = host_rsp_rdata; got = 1; end
      @(negedge clk);
    end
    host_rsp_ready = 1'b0;
  endtask

  // one access against the model, with checks
  task automatic op(input bit wr, input bit io, input logic [1:0] idx, input logic [31:0] wd);
    logic [31:0] rd, exp;
    int b0, r0;
    bit bus_exp;
    b0 = bus_cnt; r0 = bus_rsp_cnt;
    bus_exp = (idx == 2'd2) && io && m_open;
    access(wr, io, idx, wd, rd);
    exp = 32'd0;
    case (idx)
      2'd0: if (wr) m_open = (wd == KEY); else exp = {31'b0, m_open};
      2'd1: if (wr) begin if (m_open) m_addr = wd; end else exp = m_addr;
      2'd2: if (!wr) exp = bus_exp ? bus_data(m_addr) : 32'hFFFF_FFFF;
      default: exp = 32'd0;
    endcase
    if (idx == 2'd0)      check(rd == exp, wr ? "R3 key write rsp" : "R2 status read", rd, exp);
    else if (idx == 2'd1) check(rd == exp, "R4 addr access", rd, exp);
    else if (idx == 2'd3) check(rd == exp, "R10 reserved", rd, exp);
    else if (bus_exp)     check(rd == exp, wr ? "R5 bus write rsp" : "R6 bus read data", rd, exp);
    else if (!io)         check(rd == exp, "R7 mem-space data", rd, exp);
    else                  check(rd == exp, "R8 locked data", rd, exp);
    if (bus_exp) begin
      check(bus_cnt == b0 + 1, "R5 R6 one bus request", bus_cnt, b0 + 1);
      check(bus_rsp_cnt == r0 + 1, "R6 rsp after bus rsp", bus_rsp_cnt, r0 + 1);
      check(last_addr == m_addr, "R5 R6 bus addr", last_addr, m_addr);
      check(last_write == wr, "R5 R6 bus dir", {31'b0, last_write}, {31'b0, wr});
      if (wr) check(last_wdata == wd, "R5 bus wdata", last_wdata, wd);
    end else begin
      check(bus_cnt == b0, "R7 R8 no bus request", bus_cnt, b0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    finish_sim();
  end

  initial begin
    int seed;
    seed = $urandom(32'd24681);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(host_req_ready == 1'b1, "R1 req_ready", {31'b0, host_req_ready}, 32'd1);
    check(host_rsp_valid == 1'b0, "R1 rsp_valid", {31'b0, host_rsp_valid}, 32'd0);
    check(bus_req_valid == 1'b0, "R1 bus_req_valid", {31'b0, bus_req_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    op(0, 1, 2'd0, 0);                    // R1 locked
    op(0, 0, 2'd1, 0);                    // R1 addr 0
    op(1, 1, 2'd2, 32'h1111_2222);        // R8 locked write
    op(0, 1, 2'd2, 0);                    // R8 locked read
    op(1, 1, 2'd1, 32'h0000_4000);        // R4 ignored while locked
    op(0, 1, 2'd1, 0);
    op(1, 0, 2'd0, KEY);                  // R2 key via memory space
    op(0, 1, 2'd0, 0);
    op(1, 1, 2'd1, 32'h0000_4000);        // R4 accepted
    op(0, 0, 2'd1, 0);
    op(1, 1, 2'd2, 32'hCAFE_F00D);        // R5
    op(0, 1, 2'd2, 0);                    // R6
    op(0, 0, 2'd2, 0);                    // R7 read
    op(1, 0, 2'd2, 32'h7777_7777);        // R7 write
    op(1, 1, 2'd3, 32'h5555_AAAA);        // R10
    op(0, 1, 2'd3, 0);
    op(1, 1, 2'd0, KEY ^ 32'h1);          // R3 near-miss key
    op(0, 1, 2'd0, 0);
    op(0, 1, 2'd2, 0);                    // R8 after relock
    op(1, 1, 2'd0, KEY);
    op(1, 1, 2'd0, KEY);                  // R2 repeated key keeps open
    op(0, 1, 2'd0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  idx;
      logic [31:0] wd;
      idx = 2'($urandom % 4);
      wd  = $urandom;
      if (idx == 2'd0 && ($urandom % 3 != 0)) wd = KEY;
      op(1'($urandom % 2), 1'($urandom % 4 != 0), idx, wd);
    end
    done = 1'b1;
    finish_sim();
  end
endmodule